// File: doc/BRIEF.md
# Channel Deflation and Index Tracker

This block keeps the bookkeeping state of an ordered successive interference cancellation detector with four transmit streams. It stores the original channel matrix and a compact list that maps each still-undetected local position to its original antenna number. Each time the ordering logic picks a local position, the block looks up the original antenna, marks that column as cancelled, and compacts the list so that the remaining antennas again occupy the lowest local positions.

Every accepted step returns two things one cycle later: the original antenna number, which places the detected symbol, and the untouched original column, which the cancellation stage needs. Two matrix views are always present. One is the original matrix with the cancelled columns zeroed in place. The other is a view whose local column p is the original column named by list slot p, for the positions still in use. The block does no arithmetic on the matrix values.

Top module: `defl_tracker`

## Requirements
- R1: After reset, and in the cycle after a load, the index list holds slot p = p+1 for p = 0..3, remaining = 4, no column is zeroed, outValid = 0, origIdx = 0 and cancelCol = 0.
- R2: An advance with selLocal < remaining is accepted. In the next cycle origIdx equals the value the index list held at slot selLocal; original antenna numbers run from 1 to 4.
- R3: In the cycle after an accepted advance, cancelCol holds the original loaded column origIdx-1, with row r at bits [r*EW +: EW]. Columns zeroed earlier do not affect it.
- R4: An accepted advance removes slot selLocal from the index list. Each slot above it moves down by one, the top slot becomes 0, and remaining drops by 1. Slot p is at bits [p*3 +: 3].
- R5: hZeroed equals the loaded matrix with every column already picked set to zero. Entry (row r, column c) is at bits [(c*4+r)*EW +: EW].
- R6: In hOrdered, local column p < remaining equals the original column (slot p value - 1). Local columns at or above remaining are zero. The bit layout is the same as in R5.
- R7: An advance with selLocal >= remaining is ignored: the index list, remaining and both matrix views stay unchanged, and outValid stays 0. This includes every advance made once remaining = 0.
- R8: A load captures hInit and restores the R1 state. A load takes priority over an advance presented in the same cycle.
- R9: outValid is high for exactly the one cycle after each accepted advance and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadStb | input | 1 | Capture hInit and restart the sequence |
| hInit | input | N*N*EW | Channel matrix, column-major |
| advStb | input | 1 | Request one detection step |
| selLocal | input | $clog2(N) | Local position chosen by the ordering logic |
| outValid | output | 1 | Pulse marking a fresh step result |
| origIdx | output | $clog2(N+1) | Original antenna number of the last step (1-based) |
| cancelCol | output | N*EW | Original column of the last step |
| idxVec | output | N*$clog2(N+1) | Current index list |
| remaining | output | $clog2(N+1) | Number of valid list slots |
| hZeroed | output | N*N*EW | Original matrix with picked columns zeroed |
| hOrdered | output | N*N*EW | Remaining columns in index-list order |

## Verification
On every cycle the assertions check the following:
- the count of zeroed columns plus remaining always totals four;
- each accepted step shrinks remaining by exactly one;
- an idle or out-of-range request leaves the flags and count frozen;
- the reported antenna is always one whose column is already marked zeroed.

The actual values cannot be judged by a local property: which antenna comes out, the shifted list contents, the cancelled column and the reordered matrix view. The bench covers these by sweeping all 24 orders of selection against its own model, probing an out-of-range selection before every step, and testing load collisions.

// File: rtl/defl_pkg.sv
package defl_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic doLoad;
    logic doAdv;
  } ctrl_t;
endpackage

// File: rtl/defl_control.sv
module defl_control #(
  parameter int N = 4,
  localparam int CW = $clog2(N + 1),
  localparam int SW = $clog2(N)
) (
  input  logic                  loadStb,
  input  logic                  advStb,
  input  logic [SW-1:0]         selLocal,
  input  logic [CW-1:0]         remaining,
  output defl_pkg::ctrl_t       ctl
);
  // Load wins; an advance needs a selection inside the live part of the list
  always_comb begin
    ctl.doLoad = loadStb;
    ctl.doAdv  = advStb && !loadStb && (CW'(selLocal) < remaining);
  end
endmodule

// File: rtl/defl_datapath.sv
module defl_datapath #(
  parameter int N  = 4,
  parameter int EW = 32,
  localparam int CW = $clog2(N + 1),
  localparam int SW = $clog2(N)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  defl_pkg::ctrl_t       ctl,
  input  logic [N*N*EW-1:0]     hInit,
  input  logic [SW-1:0]         selLocal,
  output logic                  outValid,
  output logic [CW-1:0]         origIdx,
  output logic [N*EW-1:0]       cancelCol,
  output logic [N*CW-1:0]       idxVec,
  output logic [CW-1:0]         remaining,
  output logic [N*N*EW-1:0]     hZeroed,
  output logic [N*N*EW-1:0]     hOrdered
);
  logic [EW-1:0] hOrig [N][N];   // [column][row]
  logic [CW-1:0] idxReg [N];
  logic [CW-1:0] idxNext [N];
  logic [N-1:0]  zeroFlag;
  logic [CW-1:0] picked;
  logic [SW-1:0] pickedCol;

  assign picked    = idxReg[selLocal];
  assign pickedCol = SW'(picked - CW'(1));

  // Compacted list: slots at or above the removed one take their upper neighbour
  always_comb begin
    for (int p = 0; p < N; p++) begin
      if (p < int'(selLocal)) idxNext[p] = idxReg[p];
      else if (p == N - 1)    idxNext[p] = '0;
      else                    idxNext[p] = idxReg[(p + 1) % N];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.doLoad) begin
      for (int c = 0; c < N; c++)
        for (int r = 0; r < N; r++)
          hOrig[c][r] <= rstN ? hInit[(c*N + r)*EW +: EW] : '0;
      for (int p = 0; p < N; p++) idxReg[p] <= CW'(p + 1);
      zeroFlag  <= '0;
      remaining <= CW'(N);
      outValid  <= 1'b0;
      origIdx   <= '0;
      cancelCol <= '0;
    end else if (ctl.doAdv) begin
      for (int p = 0; p < N; p++) idxReg[p] <= idxNext[p];
      zeroFlag[pickedCol] <= 1'b1;
      remaining <= remaining - CW'(1);
      outValid  <= 1'b1;
      origIdx   <= picked;
      for (int r = 0; r < N; r++) cancelCol[r*EW +: EW] <= hOrig[pickedCol][r];
    end else begin
      outValid <= 1'b0;
    end
  end

  // Output views
  for (genvar p = 0; p < N; p++) begin : gSlot
    logic [SW-1:0] srcCol;
    logic          live;
    assign idxVec[p*CW +: CW] = idxReg[p];
    assign srcCol = SW'(idxReg[p] - CW'(1));
    assign live   = (CW'(p) < remaining) && (idxReg[p] != '0);
    for (genvar r = 0; r < N; r++) begin : gRow
      assign hZeroed[(p*N + r)*EW +: EW]  = zeroFlag[p] ? '0 : hOrig[p][r];
      assign hOrdered[(p*N + r)*EW +: EW] = live ? hOrig[srcCol][r] : '0;
    end
  end

  // Checks
  assert_remain_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    remaining <= CW'(N));
  assert_flags_match_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(zeroFlag) + int'(remaining)) == N);
  assert_shrink_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doAdv |=> (int'(remaining) == int'($past(remaining)) - 1));
  assert_ignore_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.doAdv && !ctl.doLoad) |=> ($stable(zeroFlag) && $stable(remaining) && !outValid));
  assert_pick_zeroed_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> zeroFlag[SW'(origIdx - CW'(1))]);
  assert_load_state_R1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doLoad |=> (remaining == CW'(N) && zeroFlag == '0 && !outValid));
endmodule

// File: rtl/defl_tracker.sv
module defl_tracker #(
  parameter int N  = 4,
  parameter int EW = 32,
  localparam int CW = $clog2(N + 1),
  localparam int SW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic [N*N*EW-1:0] hInit,
  input  logic              advStb,
  input  logic [SW-1:0]     selLocal,
  output logic              outValid,
  output logic [CW-1:0]     origIdx,
  output logic [N*EW-1:0]   cancelCol,
  output logic [N*CW-1:0]   idxVec,
  output logic [CW-1:0]     remaining,
  output logic [N*N*EW-1:0] hZeroed,
  output logic [N*N*EW-1:0] hOrdered
);
  defl_pkg::ctrl_t ctl;

  defl_control #(.N(N)) uCtl (
    .loadStb(loadStb), .advStb(advStb), .selLocal(selLocal),
    .remaining(remaining), .ctl(ctl)
  );

  defl_datapath #(.N(N), .EW(EW)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .hInit(hInit), .selLocal(selLocal),
    .outValid(outValid), .origIdx(origIdx), .cancelCol(cancelCol),
    .idxVec(idxVec), .remaining(remaining), .hZeroed(hZeroed), .hOrdered(hOrdered)
  );
endmodule

// File: tb/defl_tracker_test.sv
module defl_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int EW = 32;
  localparam int CW = 3;
  localparam int MW = N*N*EW;

  logic clk = 0, rstN = 0, loadStb = 0, advStb = 0;
  logic [MW-1:0] hInit = '0;
  logic [1:0] selLocal = '0;
  logic outValid;
  logic [CW-1:0] origIdx, remaining;
  logic [N*EW-1:0] cancelCol;
  logic [N*CW-1:0] idxVec;
  logic [MW-1:0] hZeroed, hOrdered;

  int tests = 0, fails = 0;
  int mIdx [N];
  bit mZero [N];
  int mRem;
  int seed;

  always #(CLK_PERIOD/2) clk = ~clk;

  defl_tracker #(.N(N), .EW(EW)) uut (.*);

  function automatic logic [EW-1:0] ent(int s, int r, int c);
    return {8'(s), 8'(r), 8'(c), 8'hC3};
  endfunction

  function automatic logic [MW-1:0] mat(int s);
    logic [MW-1:0] m;
    for (int c = 0; c < N; c++)
      for (int r = 0; r < N; r++) m[(c*N + r)*EW +: EW] = ent(s, r, c);
    return m;
  endfunction

  task automatic check(bit ok, string req, logic [MW-1:0] act, logic [MW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N*CW-1:0] expIdx();
    logic [N*CW-1:0] v;
    for (int p = 0; p < N; p++) v[p*CW +: CW] = CW'(mIdx[p]);
    return v;
  endfunction

  function automatic logic [MW-1:0] expZeroed();
    logic [MW-1:0] m;
    for (int c = 0; c < N; c++)
      for (int r = 0; r < N; r++) m[(c*N + r)*EW +: EW] = mZero[c] ? '0 : ent(seed, r, c);
    return m;
  endfunction

  function automatic logic [MW-1:0] expOrdered();
    logic [MW-1:0] m;
    for (int p = 0; p < N; p++)
      for (int r = 0; r < N; r++)
        m[(p*N + r)*EW +: EW] = (p < mRem) ? ent(seed, r, mIdx[p] - 1) : '0;
    return m;
  endfunction

  function automatic logic [N*EW-1:0] expCol(int o);
    logic [N*EW-1:0] v;
    for (int r = 0; r < N; r++) v[r*EW +: EW] = ent(seed, r, o - 1);
    return v;
  endfunction

  task automatic modelLoad(int s);
    seed = s; mRem = N;
    for (int p = 0; p < N; p++) begin mIdx[p] = p + 1; mZero[p] = 0; end
  endtask

  task automatic checkState(string tag);
    check(idxVec == expIdx(), {tag, " idxVec"}, MW'(idxVec), MW'(expIdx()));
    check(remaining == CW'(mRem), {tag, " remaining"}, MW'(remaining), MW'(mRem));
    check(hZeroed == expZeroed(), {"R5 ", tag, " hZeroed"}, hZeroed, expZeroed());
    check(hOrdered == expOrdered(), {"R6 ", tag, " hOrdered"}, hOrdered, expOrdered());
  endtask

  task automatic doLoad(int s, bit withAdv);
    @(negedge clk);
    hInit = mat(s); loadStb = 1; advStb = withAdv; selLocal = 2'd1;
    @(negedge clk);
    loadStb = 0; advStb = 0;
    modelLoad(s);
    check(outValid == 0 && origIdx == 0 && cancelCol == '0, "R1 R8 load outputs",
          MW'({outValid, origIdx}), '0);
    checkState("R1 R8 load");
  endtask

  task automatic doAdv(int sel);
    int o;
    @(negedge clk);
    advStb = 1; selLocal = 2'(sel);
    @(negedge clk);
    advStb = 0;
    if (sel < mRem) begin
      o = mIdx[sel];
      for (int p = sel; p < N - 1; p++) mIdx[p] = mIdx[p + 1];
      mIdx[N-1] = 0; mZero[o - 1] = 1; mRem--;
      check(outValid == 1, "R9 pulse high", MW'(outValid), 1);
      check(origIdx == CW'(o), "R2 origIdx", MW'(origIdx), MW'(o));
      check(cancelCol == expCol(o), "R3 cancelCol", MW'(cancelCol), MW'(expCol(o)));
      checkState("R4 step");
      @(negedge clk);
      check(outValid == 0, "R9 pulse low", MW'(outValid), 0);
    end else begin
      check(outValid == 0, "R7 ignored no pulse", MW'(outValid), 0);
      checkState("R7 ignored");
    end
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    modelLoad(0);
    seed = 0;
    check(outValid == 0 && origIdx == 0, "R1 reset outputs", MW'({outValid, origIdx}), '0);
    check(idxVec == expIdx() && remaining == CW'(N), "R1 reset list",
          MW'(idxVec), MW'(expIdx()));
    rstN = 1;
    // Every order of selection (R2..R7, R9)
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 2; c++) begin
          int seq [N];
          seq[0] = a; seq[1] = b; seq[2] = c; seq[3] = 0;
          doLoad(a*6 + b*2 + c + 1, 0);
          for (int s = 0; s < N; s++) begin
            if (mRem < N) doAdv(mRem);   // out of range, R7
            doAdv(seq[s]);
          end
          doAdv(0);  // remaining 0: ignored, R7
          doAdv(3);
        end
    // R8: load and advance in the same cycle, part way through
    doLoad(40, 0);
    doAdv(2);
    doAdv(0);
    doLoad(41, 1);
    doAdv(3);
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule